// File: doc/BRIEF.md
# Conditional Branch Resolver with Static Prediction

This block settles conditional branches that test a single condition-register bit. When a branch is presented, the resolver looks up the tested bit in a scoreboard of pending-write flags. The scoreboard holds one flag per condition bit and is driven by the execution pipeline. If the flag is clear, the bit is already valid. The branch is then decided in its arrival cycle, and fetch is steered to the resolved target.

If the flag is set, an older instruction may still change the bit. The resolver then picks a direction statically and steers fetch down that path. It keeps the branch open and watches the flag. When the flag drops, the resolver compares the real outcome with its guess. A correct guess only reports completion. A wrong guess raises a purge of the speculatively fetched instructions and redirects fetch to the other target.

Only one unresolved branch may be held at a time. While one is open, the resolver reports itself busy, and a newly presented branch waits until it is accepted.

Top module: `branch_resolver`

## Requirements
- R1: After reset, `busy`, `fetch_redir`, `purge` and `br_done` are all low.
- R2: A branch is accepted when `br_valid` is high and `busy` is low. If the scoreboard flag of the tested bit is clear when it is accepted, then in the next cycle `br_done`=1, `fetch_redir`=1 and `purge`=0. `fetch_pc` equals `br_taken_pc` when `cr_val[br_crsel]` equals `br_sense`, and `br_fall_pc` otherwise.
- R3: If the tested flag is set when the branch is accepted, then in the next cycle `fetch_redir`=1 with `fetch_pc` on the predicted target, `br_done`=0 and `purge`=0. From that cycle `busy` is 1.
- R4: The predicted direction is taken exactly when `br_disp_neg` XOR `br_hint` is 1. A negative displacement predicts taken, and the hint inverts that default.
- R5: While `busy` is 1, a presented branch is not accepted and produces no outputs. It is accepted on the first edge at which `busy` is low.
- R6: While the held branch's flag stays set, `br_done`, `purge` and `fetch_redir` stay low.
- R7: The flag is sampled low at the clock edge on which the held branch resolves. If the real outcome matches the prediction, then in the next cycle `br_done`=1, `fetch_redir`=0 and `purge`=0.
- R8: On a misprediction, the next cycle shows `br_done`=1, `purge`=1 and `fetch_redir`=1, with `fetch_pc` on the target not predicted.
- R9: `purge` and the completion of an unresolved branch last exactly one cycle. `busy` is low in the cycle that shows the resolution.
- R10: Only the tested bit's flag matters. Flags set on other condition bits do not delay resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Conditional branch presented |
| br_crsel | input | IDX_W | Index of the tested condition bit |
| br_sense | input | 1 | Bit value that makes the branch taken |
| br_disp_neg | input | 1 | Displacement sign, 1 = backward |
| br_hint | input | 1 | Inverts the default static prediction |
| br_taken_pc | input | ADDR_W | Taken target |
| br_fall_pc | input | ADDR_W | Fall-through target |
| cr_pend | input | CR_BITS | Pending-write flag per condition bit |
| cr_val | input | CR_BITS | Condition register value |
| busy | output | 1 | An unresolved branch is held |
| fetch_redir | output | 1 | Fetch redirect pulse |
| fetch_pc | output | ADDR_W | Redirect address, valid with `fetch_redir` |
| purge | output | 1 | Discard instructions fetched after the branch |
| br_done | output | 1 | Branch completed |

## Verification
The bench builds the block with CR_BITS=8 and ADDR_W=16. The narrow scoreboard lets the tests reach both the lowest and the highest condition bit. It also lets them set flags on neighbouring bits, to show that only the tested flag gates resolution. The 16-bit targets keep the taken and fall-through addresses distinct, so every redirect can be traced to the direction chosen.

// File: rtl/br_pkg.sv
package br_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } br_state_e;
endpackage

// File: rtl/br_static_pred.sv
module br_static_pred (
    input  logic disp_neg,
    input  logic hint,
    output logic pred_taken
);
    // backward branches default to taken; the hint flips the default
    always_comb begin
        pred_taken = disp_neg ^ hint;
    end
endmodule

// File: rtl/br_cr_tap.sv
module br_cr_tap #(
    parameter int CR_BITS = 32,
    localparam int IDX_W  = (CR_BITS > 1) ? $clog2(CR_BITS) : 1
) (
    input  logic [CR_BITS-1:0] pend_vec,
    input  logic [CR_BITS-1:0] val_vec,
    input  logic [IDX_W-1:0]   sel,
    output logic               pend_bit,
    output logic               val_bit
);
    always_comb begin
        pend_bit = 1'b0;
        val_bit  = 1'b0;
        for (int i = 0; i < CR_BITS; i++) begin
            if (sel == IDX_W'(i)) begin
                pend_bit = pend_vec[i];
                val_bit  = val_vec[i];
            end
        end
    end
endmodule

// File: rtl/branch_resolver.sv
module branch_resolver #(
    parameter int CR_BITS = 32,
    parameter int ADDR_W  = 32,
    localparam int IDX_W  = (CR_BITS > 1) ? $clog2(CR_BITS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               br_valid,
    input  logic [IDX_W-1:0]   br_crsel,
    input  logic               br_sense,
    input  logic               br_disp_neg,
    input  logic               br_hint,
    input  logic [ADDR_W-1:0]  br_taken_pc,
    input  logic [ADDR_W-1:0]  br_fall_pc,
    input  logic [CR_BITS-1:0] cr_pend,
    input  logic [CR_BITS-1:0] cr_val,
    output logic               busy,
    output logic               fetch_redir,
    output logic [ADDR_W-1:0]  fetch_pc,
    output logic               purge,
    output logic               br_done
);
    import br_pkg::*;

    typedef struct packed {
        br_state_e         st;
        logic [IDX_W-1:0]  idx;
        logic              sense;
        logic              pred_taken;
        logic [ADDR_W-1:0] taken_pc;
        logic [ADDR_W-1:0] fall_pc;
        logic              redir;
        logic [ADDR_W-1:0] pc;
        logic              purge;
        logic              done;
    } res_state_t;

    res_state_t q, d;

    logic arr_pend, arr_bit;
    logic hold_pend, hold_bit;
    logic pred_taken;
    logic accept;

    // scoreboard tap for the arriving branch
    br_cr_tap #(.CR_BITS(CR_BITS)) i_tap_arrive (
        .pend_vec (cr_pend),
        .val_vec  (cr_val),
        .sel      (br_crsel),
        .pend_bit (arr_pend),
        .val_bit  (arr_bit)
    );

    // scoreboard tap for the held, unresolved branch
    br_cr_tap #(.CR_BITS(CR_BITS)) i_tap_hold (
        .pend_vec (cr_pend),
        .val_vec  (cr_val),
        .sel      (q.idx),
        .pend_bit (hold_pend),
        .val_bit  (hold_bit)
    );

    br_static_pred i_pred (
        .disp_neg   (br_disp_neg),
        .hint       (br_hint),
        .pred_taken (pred_taken)
    );

    assign busy   = (q.st == ST_WAIT);
    assign accept = br_valid && !busy;

    always_comb begin
        d       = q;
        d.redir = 1'b0;
        d.purge = 1'b0;
        d.done  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (br_valid) begin
                    d.redir = 1'b1;
                    if (!arr_pend) begin
                        // bit is valid: decide now
                        d.done = 1'b1;
                        d.pc   = (arr_bit == br_sense) ? br_taken_pc : br_fall_pc;
                    end else begin
                        // interlock: speculate on the static guess
                        d.st         = ST_WAIT;
                        d.idx        = br_crsel;
                        d.sense      = br_sense;
                        d.pred_taken = pred_taken;
                        d.taken_pc   = br_taken_pc;
                        d.fall_pc    = br_fall_pc;
                        d.pc         = pred_taken ? br_taken_pc : br_fall_pc;
                    end
                end
            end
            ST_WAIT: begin
                if (!hold_pend) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    if ((hold_bit == q.sense) != q.pred_taken) begin
                        d.purge = 1'b1;
                        d.redir = 1'b1;
                        d.pc    = q.pred_taken ? q.fall_pc : q.taken_pc;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign fetch_redir = q.redir;
    assign fetch_pc    = q.pc;
    assign purge       = q.purge;
    assign br_done     = q.done;

    // R2: a clear flag at acceptance yields an immediate, purge-free completion
    assert_immediate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !arr_pend) |=> (br_done && fetch_redir && !purge));

    // R3: a set flag at acceptance yields a speculative redirect and holds the branch
    assert_speculate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && arr_pend) |=> (busy && fetch_redir && !br_done && !purge));

    // R5: a branch shown while busy produces no standalone redirect
    assert_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && br_valid) |=> !(fetch_redir && !br_done));

    // R6: nothing completes while the tested flag stays set
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && hold_pend) |=> (!br_done && !purge && !fetch_redir));

    // R8: a purge always travels with a redirect and completion
    assert_purge_redir_R8: assert property (@(posedge clk) disable iff (!rst_n)
        purge |-> (fetch_redir && br_done && !busy));

    // R9: purge is a single-cycle pulse
    assert_purge_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        purge |=> !purge);
endmodule

// File: tb/test_branch_resolver.sv
module test_branch_resolver;
    localparam int CR_BITS = 8;
    localparam int ADDR_W  = 16;
    localparam int IDX_W   = 3;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               br_valid;
    logic [IDX_W-1:0]   br_crsel;
    logic               br_sense;
    logic               br_disp_neg;
    logic               br_hint;
    logic [ADDR_W-1:0]  br_taken_pc;
    logic [ADDR_W-1:0]  br_fall_pc;
    logic [CR_BITS-1:0] cr_pend;
    logic [CR_BITS-1:0] cr_val;
    logic               busy;
    logic               fetch_redir;
    logic [ADDR_W-1:0]  fetch_pc;
    logic               purge;
    logic               br_done;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    branch_resolver #(.CR_BITS(CR_BITS), .ADDR_W(ADDR_W)) i_branch_resolver (
        .clk, .rst_n, .br_valid, .br_crsel, .br_sense, .br_disp_neg, .br_hint,
        .br_taken_pc, .br_fall_pc, .cr_pend, .cr_val,
        .busy, .fetch_redir, .fetch_pc, .purge, .br_done
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_out(input string tag, input bit e_busy, input bit e_redir,
                           input bit e_purge, input bit e_done);
        chk({tag, " busy"},  int'(busy),        int'(e_busy));
        chk({tag, " redir"}, int'(fetch_redir), int'(e_redir));
        chk({tag, " purge"}, int'(purge),       int'(e_purge));
        chk({tag, " done"},  int'(br_done),     int'(e_done));
    endtask

    // drive at the falling edge, let one rising edge pass, sample just after it
    task automatic present(input int idx, input bit sense, input bit neg, input bit hint,
                           input int tpc, input int fpc);
        @(negedge clk);
        br_valid    = 1'b1;
        br_crsel    = IDX_W'(idx);
        br_sense    = sense;
        br_disp_neg = neg;
        br_hint     = hint;
        br_taken_pc = ADDR_W'(tpc);
        br_fall_pc  = ADDR_W'(fpc);
        @(posedge clk);
        #1 br_valid = 1'b0;
    endtask

    task automatic step();
        @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        chk_out("R1 reset", 0, 0, 0, 0);
    endtask

    task automatic t_immediate();
        cr_pend = '0;
        cr_val  = 8'b0000_0001;
        present(0, 1, 0, 0, 16'h1000, 16'h2000);
        chk_out("R2 imm idx0", 0, 1, 0, 1);
        chk("R2 imm idx0 pc", int'(fetch_pc), 16'h1000);
        cr_val = 8'b0111_1111;
        present(7, 1, 1, 0, 16'h1100, 16'h2100);
        chk_out("R2 imm idx7", 0, 1, 0, 1);
        chk("R2 imm idx7 pc", int'(fetch_pc), 16'h2100);
        present(7, 0, 0, 0, 16'h1200, 16'h2200);
        chk("R2 imm sense0 pc", int'(fetch_pc), 16'h1200);
        step();
        chk_out("R9 idle after imm", 0, 0, 0, 0);
    endtask

    task automatic t_other_flags();
        cr_pend = 8'b1111_1011;
        cr_val  = 8'b0000_0100;
        present(2, 1, 0, 0, 16'h1300, 16'h2300);
        chk_out("R10 neighbours set", 0, 1, 0, 1);
        chk("R10 pc", int'(fetch_pc), 16'h1300);
        cr_pend = '0;
    endtask

    task automatic t_correct();
        cr_pend = 8'b0000_1000;
        cr_val  = '0;
        present(3, 1, 1, 0, 16'h1400, 16'h2400);
        chk_out("R3 spec", 1, 1, 0, 0);
        chk("R4 neg predicts taken pc", int'(fetch_pc), 16'h1400);
        for (int i = 0; i < 3; i++) begin
            step();
            chk_out("R6 hold", 1, 0, 0, 0);
        end
        @(negedge clk);
        cr_pend = '0;
        cr_val  = 8'b0000_1000;
        @(posedge clk);
        #1;
        chk_out("R7 correct", 0, 0, 0, 1);
        step();
        chk_out("R9 after correct", 0, 0, 0, 0);
    endtask

    task automatic t_wrong();
        cr_pend = 8'b0010_0000;
        cr_val  = '0;
        present(5, 1, 0, 0, 16'h1500, 16'h2500);
        chk_out("R3 spec fwd", 1, 1, 0, 0);
        chk("R4 fwd predicts fall pc", int'(fetch_pc), 16'h2500);
        @(negedge clk);
        cr_pend = '0;
        cr_val  = 8'b0010_0000;
        @(posedge clk);
        #1;
        chk_out("R8 wrong", 0, 1, 1, 1);
        chk("R8 wrong pc", int'(fetch_pc), 16'h1500);
        step();
        chk_out("R9 purge pulse", 0, 0, 0, 0);
    endtask

    task automatic t_hint();
        cr_pend = 8'b0000_0010;
        cr_val  = 8'b0000_0010;
        present(1, 0, 0, 1, 16'h1600, 16'h2600);
        chk("R4 hint predicts taken pc", int'(fetch_pc), 16'h1600);
        @(negedge clk);
        cr_pend = '0;
        @(posedge clk);
        #1;
        chk_out("R8 hint wrong", 0, 1, 1, 1);
        chk("R8 hint wrong pc", int'(fetch_pc), 16'h2600);
    endtask

    task automatic t_stall();
        cr_pend = 8'b0100_0000;
        cr_val  = 8'b0000_0001;
        present(6, 0, 1, 0, 16'h1700, 16'h2700);
        chk_out("R3 first spec", 1, 1, 0, 0);
        @(negedge clk);
        br_valid    = 1'b1;
        br_crsel    = 3'd0;
        br_sense    = 1'b1;
        br_disp_neg = 1'b0;
        br_hint     = 1'b0;
        br_taken_pc = 16'h1800;
        br_fall_pc  = 16'h2800;
        @(posedge clk);
        #1;
        chk_out("R5 second stalled", 1, 0, 0, 0);
        @(negedge clk);
        cr_pend = '0;
        @(posedge clk);
        #1;
        chk_out("R5 first resolves", 0, 0, 0, 1);
        @(posedge clk);
        #1 br_valid = 1'b0;
        chk_out("R5 second accepted", 0, 1, 0, 1);
        chk("R5 second pc", int'(fetch_pc), 16'h1800);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        br_valid = 1'b0;
        br_crsel = '0;
        br_sense = 1'b0;
        br_disp_neg = 1'b0;
        br_hint = 1'b0;
        br_taken_pc = '0;
        br_fall_pc = '0;
        cr_pend = '0;
        cr_val = '0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_immediate();
        t_other_flags();
        t_correct();
        t_wrong();
        t_hint();
        t_stall();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule